// File: doc/BRIEF.md
# Display Mode-Set Power Sequencer

This block walks a display path through a complete mode change. One host start pulse is enough: the block tears the selected path down, then brings it up again in the new mode. Teardown switches off the output connectors, then the planes, then the timing pipe, then the pixel-clock PLL. Bring-up runs in the exact reverse order. After the PLL is enabled, bring-up pauses until the PLL reports lock, and only then enables the pipe.

Every sub-unit gets a one-cycle strobe and must return an acknowledge before the sequence moves on. Each step has a timeout. A missed acknowledge or a late lock aborts the sequence: all disables fire together, the error flag is raised and the block returns to idle.

There are two pipelines, each with its own PLL, pipe and planes. The connectors are shared between the pipelines, and a mask chooses which connectors follow the selected pipe. Timing words, framebuffer base and stride are copied from shadow inputs into per-pipe output registers. Each copy happens only at the bring-up step that needs it.

Top module: `modeset_seq`

## Requirements
- R1: After a start pulse in idle, teardown issues connector-disable (bits of the captured connector mask), then plane-disable (all planes of the pipe), then pipe-disable, then PLL-disable. Each strobe follows the acknowledge of the previous step.
- R2: Bring-up then issues PLL-enable, waits for lock, then pipe-enable, then plane-enable, then connector-enable (captured mask). `done_o` rises in the cycle after the connector acknowledge and stays high until the next accepted start.
- R3: Each strobe is high for exactly one cycle, in the first cycle of its step. When an acknowledge is high in cycle k, the strobe of the following step appears in cycle k+1. Enable and disable strobes are never high together.
- R4: Pipe-enable appears only in the cycle after `pll_lock_i` of the selected pipe is seen high during the lock wait.
- R5: The lock wait lasts at most `lock_limit_i` cycles, a value captured at start, with 0 counting as 1. If lock is not seen by then, the sequence aborts with `error_o` high and no pipe-enable is issued.
- R6: Every acknowledge step times out after STEP_TIMEOUT cycles (default 16) without its acknowledge, and the sequence aborts.
- R7: An abort is one cycle in which connector, plane, pipe and PLL disables fire together for the captured pipe and mask. `error_o` rises in that cycle. The block is idle in the next cycle, and `error_o` stays high until the next accepted start.
- R8: Plane vectors use bit pipe*NUM_PLANES+k, where k=0 is the primary plane and k≥1 is secondary plane k. Enable always sets the primary bit and sets a secondary bit only when `sec_mask_i[k-1]` was set at start.
- R9: The timing word of the pipe is loaded from `timing_sh_i` in the cycle its pipe-enable appears. Base and stride (fields pipe*ADDR_W and pipe*STRIDE_W) load with plane-enable. At all other times these outputs hold.
- R10: `busy_o` is high from the cycle after an accepted start until the block is idle again. A start while busy is ignored, and so is any change to the selection inputs.
- R11: `pipe_sel_i` picks the pipe. The pipe, plane and PLL strobes of the other pipe stay low for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a mode change |
| pipe_sel_i | input | PIPE_W | Pipe to reprogram |
| sec_mask_i | input | NUM_PLANES-1 | Secondary planes to enable |
| conn_mask_i | input | NUM_CONN | Connectors that follow this pipe |
| lock_limit_i | input | LOCK_W | Lock wait limit in cycles |
| timing_sh_i | input | TIMING_W | Shadow timing word |
| base_sh_i | input | ADDR_W | Shadow framebuffer base |
| stride_sh_i | input | STRIDE_W | Shadow stride |
| conn_ack_i | input | 1 | Connector acknowledge |
| plane_ack_i | input | 1 | Plane acknowledge |
| pipe_ack_i | input | 1 | Pipe acknowledge |
| pll_ack_i | input | 1 | PLL acknowledge |
| pll_lock_i | input | NUM_PIPES | PLL lock per pipe |
| conn_en_o | output | NUM_CONN | Connector enable strobes |
| conn_dis_o | output | NUM_CONN | Connector disable strobes |
| plane_en_o | output | NUM_PIPES*NUM_PLANES | Plane enable strobes |
| plane_dis_o | output | NUM_PIPES*NUM_PLANES | Plane disable strobes |
| pipe_en_o | output | NUM_PIPES | Pipe enable strobes |
| pipe_dis_o | output | NUM_PIPES | Pipe disable strobes |
| pll_en_o | output | NUM_PIPES | PLL enable strobes |
| pll_dis_o | output | NUM_PIPES | PLL disable strobes |
| timing_o | output | NUM_PIPES*TIMING_W | Loaded timing words |
| base_o | output | NUM_PIPES*ADDR_W | Loaded framebuffer bases |
| stride_o | output | NUM_PIPES*STRIDE_W | Loaded strides |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed |
| error_o | output | 1 | Last sequence aborted |

## Verification
Some properties are checked by assertions in every cycle:
- pipe-enable only ever follows an observed lock;
- strobes are single-cycle, and enable and disable strobes never coincide;
- busy only rises after a start;
- an abort always carries the PLL and pipe disables;
- done and error are exclusive;
- timing, base and stride hold whenever their strobe is absent.

Other behaviour needs the bench scenarios and their reference model. That covers the exact step order and the one-cycle reaction to acknowledges, the lock and step timeout cycles, secondary-plane masking, isolation of the unselected pipe, and a start ignored while busy.

// File: rtl/modeset_pkg.sv
package modeset_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DCONN, ST_DPLANE, ST_DPIPE, ST_DPLL,
    ST_EPLL, ST_LOCK, ST_EPIPE, ST_EPLANE, ST_ECONN, ST_ABORT
  } seq_state_e;

  typedef struct packed {
    logic conn_en;
    logic conn_dis;
    logic plane_en;
    logic plane_dis;
    logic pipe_en;
    logic pipe_dis;
    logic pll_en;
    logic pll_dis;
    logic ld_timing;
    logic ld_fb;
  } strobe_t;

  // strobes issued on entry to a step
  function automatic strobe_t step_strobes(seq_state_e s);
    strobe_t r;
    r = '0;
    case (s)
      ST_DCONN:  r.conn_dis  = 1'b1;
      ST_DPLANE: r.plane_dis = 1'b1;
      ST_DPIPE:  r.pipe_dis  = 1'b1;
      ST_DPLL:   r.pll_dis   = 1'b1;
      ST_EPLL:   r.pll_en    = 1'b1;
      ST_EPIPE:  begin r.pipe_en = 1'b1; r.ld_timing = 1'b1; end
      ST_EPLANE: begin r.plane_en = 1'b1; r.ld_fb = 1'b1; end
      ST_ECONN:  r.conn_en   = 1'b1;
      ST_ABORT:  begin
        r.conn_dis = 1'b1; r.plane_dis = 1'b1;
        r.pipe_dis = 1'b1; r.pll_dis   = 1'b1;
      end
      default:   r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ms_step_timer.sv
module ms_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  // limit 0 behaves as 1
  assign expired_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

endmodule

// File: rtl/ms_strobe_gen.sv
module ms_strobe_gen
  import modeset_pkg::*;
#(
  parameter int NUM_PIPES  = 2,
  parameter int NUM_PLANES = 3,
  parameter int NUM_CONN   = 4,
  parameter int PIPE_W     = 1
) (
  input  strobe_t                         stb_i,
  input  logic [PIPE_W-1:0]               pipe_i,
  input  logic [NUM_PLANES-2:0]           sec_mask_i,
  input  logic [NUM_CONN-1:0]             conn_mask_i,
  output logic [NUM_CONN-1:0]             conn_en_o,
  output logic [NUM_CONN-1:0]             conn_dis_o,
  output logic [NUM_PIPES*NUM_PLANES-1:0] plane_en_o,
  output logic [NUM_PIPES*NUM_PLANES-1:0] plane_dis_o,
  output logic [NUM_PIPES-1:0]            pipe_en_o,
  output logic [NUM_PIPES-1:0]            pipe_dis_o,
  output logic [NUM_PIPES-1:0]            pll_en_o,
  output logic [NUM_PIPES-1:0]            pll_dis_o
);

  assign conn_en_o  = stb_i.conn_en  ? conn_mask_i : '0;
  assign conn_dis_o = stb_i.conn_dis ? conn_mask_i : '0;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic sel;
    assign sel           = (pipe_i == PIPE_W'(p));
    assign pipe_en_o[p]  = sel & stb_i.pipe_en;
    assign pipe_dis_o[p] = sel & stb_i.pipe_dis;
    assign pll_en_o[p]   = sel & stb_i.pll_en;
    assign pll_dis_o[p]  = sel & stb_i.pll_dis;
    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
      assign plane_dis_o[p*NUM_PLANES+k] = sel & stb_i.plane_dis;
      if (k == 0) begin : g_prim
        assign plane_en_o[p*NUM_PLANES+k] = sel & stb_i.plane_en;
      end else begin : g_sec
        assign plane_en_o[p*NUM_PLANES+k] = sel & stb_i.plane_en & sec_mask_i[k-1];
      end
    end
  end

endmodule

// File: rtl/ms_shadow_latch.sv
module ms_shadow_latch #(
  parameter int NUM_PIPES = 2,
  parameter int TIMING_W  = 32,
  parameter int ADDR_W    = 32,
  parameter int STRIDE_W  = 16,
  parameter int PIPE_W    = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ld_timing_i,
  input  logic                          ld_fb_i,
  input  logic [PIPE_W-1:0]             pipe_i,
  input  logic [TIMING_W-1:0]           timing_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [STRIDE_W-1:0]           stride_i,
  output logic [NUM_PIPES*TIMING_W-1:0] timing_o,
  output logic [NUM_PIPES*ADDR_W-1:0]   base_o,
  output logic [NUM_PIPES*STRIDE_W-1:0] stride_o
);

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic [TIMING_W-1:0] tim_q;
    logic [ADDR_W-1:0]   base_q;
    logic [STRIDE_W-1:0] str_q;
    logic                hit;
    assign hit = (pipe_i == PIPE_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tim_q  <= '0;
        base_q <= '0;
        str_q  <= '0;
      end else begin
        if (ld_timing_i && hit) tim_q <= timing_i;
        if (ld_fb_i && hit) begin
          base_q <= base_i;
          str_q  <= stride_i;
        end
      end
    end

    assign timing_o[p*TIMING_W +: TIMING_W] = tim_q;
    assign base_o[p*ADDR_W +: ADDR_W]       = base_q;
    assign stride_o[p*STRIDE_W +: STRIDE_W] = str_q;
  end

endmodule

// File: rtl/modeset_seq.sv
module modeset_seq
  import modeset_pkg::*;
#(
  parameter int NUM_PIPES    = 2,
  parameter int NUM_PLANES   = 3,
  parameter int NUM_CONN     = 4,
  parameter int TIMING_W     = 32,
  parameter int ADDR_W       = 32,
  parameter int STRIDE_W     = 16,
  parameter int LOCK_W       = 16,
  parameter int STEP_TIMEOUT = 16,
  localparam int PIPE_W      = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int NPL         = NUM_PIPES * NUM_PLANES
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [PIPE_W-1:0]             pipe_sel_i,
  input  logic [NUM_PLANES-2:0]         sec_mask_i,
  input  logic [NUM_CONN-1:0]           conn_mask_i,
  input  logic [LOCK_W-1:0]             lock_limit_i,
  input  logic [TIMING_W-1:0]           timing_sh_i,
  input  logic [ADDR_W-1:0]             base_sh_i,
  input  logic [STRIDE_W-1:0]           stride_sh_i,
  input  logic                          conn_ack_i,
  input  logic                          plane_ack_i,
  input  logic                          pipe_ack_i,
  input  logic                          pll_ack_i,
  input  logic [NUM_PIPES-1:0]          pll_lock_i,
  output logic [NUM_CONN-1:0]           conn_en_o,
  output logic [NUM_CONN-1:0]           conn_dis_o,
  output logic [NPL-1:0]                plane_en_o,
  output logic [NPL-1:0]                plane_dis_o,
  output logic [NUM_PIPES-1:0]          pipe_en_o,
  output logic [NUM_PIPES-1:0]          pipe_dis_o,
  output logic [NUM_PIPES-1:0]          pll_en_o,
  output logic [NUM_PIPES-1:0]          pll_dis_o,
  output logic [NUM_PIPES*TIMING_W-1:0] timing_o,
  output logic [NUM_PIPES*ADDR_W-1:0]   base_o,
  output logic [NUM_PIPES*STRIDE_W-1:0] stride_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          error_o
);

  localparam int STEP_W = $clog2(STEP_TIMEOUT + 1);
  localparam int CNT_W  = (LOCK_W > STEP_W) ? LOCK_W : STEP_W;

  seq_state_e              state_q, state_d;
  strobe_t                 stb_q, stb_d;
  logic [PIPE_W-1:0]       pipe_q;
  logic [NUM_PLANES-2:0]   sec_q;
  logic [NUM_CONN-1:0]     conn_q;
  logic [LOCK_W-1:0]       lock_lim_q;
  logic                    done_q, err_q;
  logic                    step_ack, expired, restart, accept;
  logic [CNT_W-1:0]        lim;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign lim     = (state_q == ST_LOCK) ? CNT_W'(lock_lim_q) : CNT_W'(STEP_TIMEOUT);
  assign restart = (state_d != state_q);

  always_comb begin
    case (state_q)
      ST_DCONN, ST_ECONN:   step_ack = conn_ack_i;
      ST_DPLANE, ST_EPLANE: step_ack = plane_ack_i;
      ST_DPIPE, ST_EPIPE:   step_ack = pipe_ack_i;
      ST_DPLL, ST_EPLL:     step_ack = pll_ack_i;
      ST_LOCK:              step_ack = pll_lock_i[pipe_q];
      default:              step_ack = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_DCONN;
      ST_ABORT: state_d = ST_IDLE;
      default: begin
        if (step_ack) begin
          state_d = (state_q == ST_ECONN) ? ST_IDLE : seq_state_e'(state_q + 4'd1);
        end else if (expired) begin
          state_d = ST_ABORT;
        end
      end
    endcase
  end

  assign stb_d = restart ? step_strobes(state_d) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      stb_q      <= '0;
      pipe_q     <= '0;
      sec_q      <= '0;
      conn_q     <= '0;
      lock_lim_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      if (accept) begin
        pipe_q     <= pipe_sel_i;
        sec_q      <= sec_mask_i;
        conn_q     <= conn_mask_i;
        lock_lim_q <= lock_limit_i;
        done_q     <= 1'b0;
        err_q      <= 1'b0;
      end
      if (state_q == ST_ECONN && state_d == ST_IDLE) done_q <= 1'b1;
      if (state_d == ST_ABORT && state_q != ST_ABORT) err_q <= 1'b1;
    end
  end

  ms_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .limit_i   (lim),
    .expired_o (expired)
  );

  ms_strobe_gen #(
    .NUM_PIPES(NUM_PIPES), .NUM_PLANES(NUM_PLANES),
    .NUM_CONN(NUM_CONN), .PIPE_W(PIPE_W)
  ) u_stb (
    .stb_i       (stb_q),
    .pipe_i      (pipe_q),
    .sec_mask_i  (sec_q),
    .conn_mask_i (conn_q),
    .conn_en_o   (conn_en_o),
    .conn_dis_o  (conn_dis_o),
    .plane_en_o  (plane_en_o),
    .plane_dis_o (plane_dis_o),
    .pipe_en_o   (pipe_en_o),
    .pipe_dis_o  (pipe_dis_o),
    .pll_en_o    (pll_en_o),
    .pll_dis_o   (pll_dis_o)
  );

  ms_shadow_latch #(
    .NUM_PIPES(NUM_PIPES), .TIMING_W(TIMING_W), .ADDR_W(ADDR_W),
    .STRIDE_W(STRIDE_W), .PIPE_W(PIPE_W)
  ) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_timing_i (stb_d.ld_timing),
    .ld_fb_i     (stb_d.ld_fb),
    .pipe_i      (pipe_q),
    .timing_i    (timing_sh_i),
    .base_i      (base_sh_i),
    .stride_i    (stride_sh_i),
    .timing_o    (timing_o),
    .base_o      (base_o),
    .stride_o    (stride_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

  // pipe only comes up behind a seen lock
  assert_pipe_after_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pipe_en_o) |-> $past(pll_lock_i[pipe_q]));

  assert_no_mixed_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|{conn_en_o, plane_en_o, pipe_en_o, pll_en_o}) &&
      (|{conn_dis_o, plane_dis_o, pipe_dis_o, pll_dis_o})));

  assert_conn_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|conn_en_o) |=> !(|conn_en_o));

  assert_plane_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|plane_en_o) |=> !(|plane_en_o));

  assert_busy_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_status_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  assert_abort_disables_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> ((|pll_dis_o) && (|pipe_dis_o) && !(|pipe_en_o)));

  assert_timing_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pipe_en_o) |-> $stable(timing_o));

  assert_fb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|plane_en_o) |-> ($stable(base_o) && $stable(stride_o)));

endmodule

// File: tb/sim_modeset_seq.sv
`timescale 1ns/1ps
module sim_modeset_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [0:0]  psel = '0;
  logic [1:0]  sec = '0;
  logic [3:0]  cmask = '0;
  logic [15:0] llim = '0;
  logic [31:0] tsh = '0, bsh = '0;
  logic [15:0] ssh = '0;
  logic        conn_ack = 0, plane_ack = 0, pipe_ack = 0, pll_ack = 0;
  logic [1:0]  lock = '0;

  logic [3:0]  conn_en, conn_dis;
  logic [5:0]  plane_en, plane_dis;
  logic [1:0]  pipe_en, pipe_dis, pll_en, pll_dis;
  logic [63:0] timing, base;
  logic [31:0] stride;
  logic        busy, done, error;

  always #2.5 clk = ~clk;

  modeset_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pipe_sel_i(psel),
    .sec_mask_i(sec), .conn_mask_i(cmask), .lock_limit_i(llim),
    .timing_sh_i(tsh), .base_sh_i(bsh), .stride_sh_i(ssh),
    .conn_ack_i(conn_ack), .plane_ack_i(plane_ack), .pipe_ack_i(pipe_ack),
    .pll_ack_i(pll_ack), .pll_lock_i(lock),
    .conn_en_o(conn_en), .conn_dis_o(conn_dis), .plane_en_o(plane_en),
    .plane_dis_o(plane_dis), .pipe_en_o(pipe_en), .pipe_dis_o(pipe_dis),
    .pll_en_o(pll_en), .pll_dis_o(pll_dis), .timing_o(timing), .base_o(base),
    .stride_o(stride), .busy_o(busy), .done_o(done), .error_o(error)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input string tag, input string nm, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, nm, a, e, cyc);
    end
  endtask

  // reference model: step numbers 0 idle,1-4 teardown,5 pll on,6 lock wait,7-9 bring-up,10 abort
  int          ms, mcnt, mpipe, mlim;
  logic [1:0]  msec;
  logic [3:0]  mconn;
  logic        mdone, merr;
  logic [63:0] mtim, mbase;
  logic [31:0] mstr;
  logic [3:0]  e_cen, e_cdis;
  logic [5:0]  e_pen, e_pdis;
  logic [1:0]  e_ien, e_idis, e_len, e_ldis;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mpipe = 0; mlim = 0; msec = 0; mconn = 0;
      mdone = 0; merr = 0; mtim = 0; mbase = 0; mstr = 0;
      e_cen = 0; e_cdis = 0; e_pen = 0; e_pdis = 0;
      e_ien = 0; e_idis = 0; e_len = 0; e_ldis = 0;
    end else begin
      int nxt;
      int lim;
      logic a;
      nxt = ms;
      lim = (ms == 6) ? mlim : 16;
      case (ms)
        1, 9: a = conn_ack;
        2, 8: a = plane_ack;
        3, 7: a = pipe_ack;
        4, 5: a = pll_ack;
        6:    a = lock[mpipe];
        default: a = 0;
      endcase
      if (ms == 0) begin
        if (start) begin
          nxt = 1; mpipe = int'(psel); msec = sec; mconn = cmask; mlim = int'(llim);
          mdone = 0; merr = 0;
        end
      end else if (ms == 10) nxt = 0;
      else if (a) nxt = (ms == 9) ? 0 : ms + 1;
      else if (mcnt + 1 >= lim) nxt = 10;
      e_cen = 0; e_cdis = 0; e_pen = 0; e_pdis = 0;
      e_ien = 0; e_idis = 0; e_len = 0; e_ldis = 0;
      if (nxt != ms) begin
        if (nxt == 1 || nxt == 10) e_cdis = mconn;
        if (nxt == 2 || nxt == 10) e_pdis = 6'(7 << (3 * mpipe));
        if (nxt == 3 || nxt == 10) e_idis = 2'(1 << mpipe);
        if (nxt == 4 || nxt == 10) e_ldis = 2'(1 << mpipe);
        if (nxt == 5) e_len = 2'(1 << mpipe);
        if (nxt == 7) begin e_ien = 2'(1 << mpipe); mtim[mpipe*32 +: 32] = tsh; end
        if (nxt == 8) begin
          e_pen = 6'({msec, 1'b1}) << (3 * mpipe);
          mbase[mpipe*32 +: 32] = bsh; mstr[mpipe*16 +: 16] = ssh;
        end
        if (nxt == 9) e_cen = mconn;
        if (nxt == 10) merr = 1;
        if (ms == 9 && nxt == 0) mdone = 1;
      end
      mcnt = (nxt != ms) ? 0 : mcnt + 1;
      ms = nxt;
    end
  end

  // responder settings and monitors
  int   dly = 1, lock_dly = 3;
  logic block_plane = 0, block_lock = 0;
  int   c_conn = -1, c_plane = -1, c_pipe = -1, c_pll = -1;
  int   c_lock [2] = '{-1, -1};
  int   n_cdis = 0, n_pe = 0, n_p0 = 0, n_ldis = 0;

  always @(negedge clk) begin
    cyc++;
    check("R1", "conn_dis", 64'(conn_dis), 64'(e_cdis));
    check("R1 R8", "plane_dis", 64'(plane_dis), 64'(e_pdis));
    check("R1", "pipe_dis", 64'(pipe_dis), 64'(e_idis));
    check("R1 R7", "pll_dis", 64'(pll_dis), 64'(e_ldis));
    check("R2 R11", "pll_en", 64'(pll_en), 64'(e_len));
    check("R4", "pipe_en", 64'(pipe_en), 64'(e_ien));
    check("R8", "plane_en", 64'(plane_en), 64'(e_pen));
    check("R2", "conn_en", 64'(conn_en), 64'(e_cen));
    check("R9", "timing", timing, mtim);
    check("R9", "base", base, mbase);
    check("R9", "stride", 64'(stride), 64'(mstr));
    check("R10", "busy", 64'(busy), 64'(ms != 0));
    check("R10", "done", 64'(done), 64'(mdone));
    check("R5 R6", "error", 64'(error), 64'(merr));
    if (|conn_dis) n_cdis++;
    if (|pipe_en) n_pe++;
    if (pipe_en[0] | pipe_dis[0] | pll_en[0] | pll_dis[0] | (|plane_en[2:0]) | (|plane_dis[2:0])) n_p0++;
    if (|pll_dis) n_ldis++;
    // responder
    conn_ack = 0; plane_ack = 0; pipe_ack = 0; pll_ack = 0;
    if (c_conn == 0) conn_ack = 1;   if (c_conn >= 0) c_conn--;
    if (c_plane == 0) plane_ack = 1; if (c_plane >= 0) c_plane--;
    if (c_pipe == 0) pipe_ack = 1;   if (c_pipe >= 0) c_pipe--;
    if (c_pll == 0) pll_ack = 1;     if (c_pll >= 0) c_pll--;
    for (int p = 0; p < 2; p++) begin
      if (c_lock[p] == 0) lock[p] = 1;
      if (c_lock[p] >= 0) c_lock[p]--;
    end
    if (|{conn_en, conn_dis}) c_conn = dly;
    if (|{plane_en, plane_dis} && !block_plane) c_plane = dly;
    if (|{pipe_en, pipe_dis}) c_pipe = dly;
    if (|{pll_en, pll_dis}) c_pll = dly;
    for (int p = 0; p < 2; p++) begin
      if (pll_en[p] && !block_lock) c_lock[p] = lock_dly;
      if (pll_dis[p]) begin lock[p] = 0; c_lock[p] = -1; end
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input logic [0:0] p, input logic [1:0] s, input logic [3:0] cm, input logic [15:0] l);
    @(negedge clk);
    psel = p; sec = s; cmask = cm; llim = l; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10", "reset busy", 64'(busy), 0);
    check("R9", "reset timing", timing, 0);
    rst_n = 1;

    // S1: pipe 0, one secondary plane
    tsh = 32'h1111_0400; bsh = 32'h8000_0000; ssh = 16'h0a00;
    n_cdis = 0;
    run(1'b0, 2'b01, 4'b0011, 16'd20);
    wait_idle();
    check("R2", "S1 done", 64'(done), 1);
    check("R3", "S1 conn_dis cycles", 64'(n_cdis), 1);

    // S2: pipe 1, all secondaries, zero ack delay, ignored restart, shadow writes in teardown
    dly = 0; lock_dly = 2; n_p0 = 0;
    run(1'b1, 2'b11, 4'b1000, 16'd30);
    tsh = 32'h2222_0780; bsh = 32'h9000_1000; ssh = 16'h1e00;
    @(negedge clk);
    start = 1; psel = 1'b0; sec = 2'b00; cmask = 4'b0001;
    @(negedge clk);
    start = 0;
    wait_idle();
    check("R11", "S2 pipe0 strobes", 64'(n_p0), 0);
    check("R10", "S2 done after ignored start", 64'(done), 1);

    // S3: lock never arrives
    dly = 1; block_lock = 1; n_pe = 0; n_ldis = 0;
    run(1'b0, 2'b10, 4'b0100, 16'd8);
    wait_idle();
    check("R5", "S3 error", 64'(error), 1);
    check("R5", "S3 pipe_en count", 64'(n_pe), 0);
    check("R7", "S3 pll_dis count", 64'(n_ldis), 2);
    block_lock = 0;

    // S4: plane ack missing in teardown
    block_plane = 1; n_pe = 0;
    run(1'b1, 2'b01, 4'b0010, 16'd10);
    wait_idle();
    check("R6", "S4 error", 64'(error), 1);
    check("R6", "S4 done", 64'(done), 0);
    check("R7", "S4 pipe_en count", 64'(n_pe), 0);
    block_plane = 0;

    // S5: no secondaries, tightest lock limit with early lock
    dly = 0; lock_dly = 0;
    tsh = 32'h3333_0320; bsh = 32'ha000_0000; ssh = 16'h0640;
    run(1'b0, 2'b00, 4'b1111, 16'd0);
    wait_idle();
    check("R5", "S5 done at limit 0", 64'(done), 1);
    check("R8", "S5 error", 64'(error), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule